// File: doc/BRIEF.md
# Micro-op Condition Skip Evaluator

This block sits beside a microcode sequencer. Each micro-instruction carries a 4-bit condition-select field. The evaluator uses that code to pick one test. The test can be a single bit of the 16-bit instruction register, a test that a low field of that register is non-zero, or one of the overflow, link, zero and negative flags.

The boolean result is not used as a branch in the same cycle. It is captured in a flip-flop at the clock edge that ends the current micro-instruction. It then drives a single bit of the following micro-instruction's microcode address. The bit is valid for that one following micro-instruction only. A micro-instruction that selects no test returns the bit to false.

Top module: `uop_skip_eval`

## Requirements
- R1: While rst_ni is low, skip_o is 0. Asserting rst_ni low clears skip_o without waiting for a clock edge.
- R2: A select code of 0 (binary 0000) makes skip_o 0 after the next rising clock edge.
- R3: Select codes 1 to 7 test instruction bit (code + 2). Code 1 tests ir_i[3] and code 7 tests ir_i[9]. After the next edge, skip_o equals that bit.
- R4: Select codes 8 and 9 (binary 1000, 1001) are reserved. They make skip_o 0 after the next edge, whatever the IR and flag values.
- R5: After the next edge, select code 10 gives skip_o = flag_v_i, code 11 gives flag_l_i, code 12 gives flag_z_i and code 13 gives flag_n_i.
- R6: Select code 14 (binary 1110) makes skip_o 1 after the next edge exactly when ir_i[2:0] is not all zero.
- R7: Select code 15 (binary 1111) makes skip_o 1 after the next edge exactly when ir_i[3:0] is not all zero.
- R8: Each result holds for exactly the one cycle after its edge. At the edge after that, skip_o takes the result of the newer select code, even when that result is 0.
- R9: Input changes between clock edges do not change skip_o until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_sel_i | input | 4 | Condition-select field of the current micro-instruction |
| ir_i | input | 16 | Instruction register contents |
| flag_v_i | input | 1 | Overflow flag |
| flag_l_i | input | 1 | Link flag |
| flag_z_i | input | 1 | Zero flag |
| flag_n_i | input | 1 | Negative flag |
| skip_o | output | 1 | Registered skip bit for the next micro-instruction |

## Verification
Every select result is due one rising edge after the code and operands are applied. The bench drives inputs on the falling edge and computes the expected bit from those values. It compares skip_o on the following falling edge, so exactly one register lies between stimulus and check. The mid-cycle checks change operands shortly after a falling edge and sample before the next rising edge, where skip_o must still hold the old result. The reset checks sample a moment after rst_ni falls, with no edge in between.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int unsigned SEL_W     = 4;
  localparam int unsigned IR_W      = 16;
  localparam int unsigned N_CODES   = 1 << SEL_W;
  localparam int unsigned IRB_FIRST = 1;   // first single-bit IR test code
  localparam int unsigned IRB_LAST  = 7;   // last single-bit IR test code
  localparam int unsigned IRB_OFS   = 2;   // code n tests ir[n + IRB_OFS]
  localparam int unsigned IR_USED   = IRB_LAST + IRB_OFS + 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE = 4'd0,
    SEL_RSV8 = 4'd8,
    SEL_RSV9 = 4'd9,
    SEL_V    = 4'd10,
    SEL_L    = 4'd11,
    SEL_Z    = 4'd12,
    SEL_N    = 4'd13,
    SEL_LO3  = 4'd14,
    SEL_LO4  = 4'd15
  } sel_code_e;

  typedef struct packed {
    logic v;
    logic l;
    logic z;
    logic n;
  } flags_t;
endpackage

// File: rtl/skip_cand_gen.sv
module skip_cand_gen
  import skip_pkg::*;
(
  input  logic [IR_W-1:0]    ir_i,
  input  flags_t             flags_i,
  output logic [N_CODES-1:0] cand_o
);
  logic lo3_nz, lo4_nz;
  assign lo3_nz = |ir_i[2:0];
  assign lo4_nz = lo3_nz | ir_i[3];

  for (genvar c = 0; c < int'(N_CODES); c++) begin : g_cand
    if (c >= int'(IRB_FIRST) && c <= int'(IRB_LAST)) begin : g_irb
      assign cand_o[c] = ir_i[c + int'(IRB_OFS)];
    end else if (c == int'(SEL_V)) begin : g_v
      assign cand_o[c] = flags_i.v;
    end else if (c == int'(SEL_L)) begin : g_l
      assign cand_o[c] = flags_i.l;
    end else if (c == int'(SEL_Z)) begin : g_z
      assign cand_o[c] = flags_i.z;
    end else if (c == int'(SEL_N)) begin : g_n
      assign cand_o[c] = flags_i.n;
    end else if (c == int'(SEL_LO3)) begin : g_lo3
      assign cand_o[c] = lo3_nz;
    end else if (c == int'(SEL_LO4)) begin : g_lo4
      assign cand_o[c] = lo4_nz;
    end else begin : g_false
      // no-op and reserved codes
      assign cand_o[c] = 1'b0;
    end
  end
endmodule

// File: rtl/skip_sel_pick.sv
module skip_sel_pick
  import skip_pkg::*;
(
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [N_CODES-1:0] cand_i,
  output logic               hit_o
);
  logic [N_CODES-1:0] sel_oh;

  always_comb begin
    sel_oh = '0;
    sel_oh[sel_i] = 1'b1;
  end

  // flat AND-OR keeps the path one decode plus one reduction deep
  assign hit_o = |(sel_oh & cand_i);
endmodule

// File: rtl/skip_hold_reg.sv
module skip_hold_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/uop_skip_eval.sv
module uop_skip_eval
  import skip_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] cond_sel_i,
  input  logic [IR_W-1:0]  ir_i,
  input  logic             flag_v_i,
  input  logic             flag_l_i,
  input  logic             flag_z_i,
  input  logic             flag_n_i,
  output logic             skip_o
);
  flags_t             flags;
  logic [N_CODES-1:0] cand;
  logic               hit;
  logic               unused_ir_hi;

  assign flags = '{v: flag_v_i, l: flag_l_i, z: flag_z_i, n: flag_n_i};
  // upper IR bits belong to other decoders
  assign unused_ir_hi = ^ir_i[IR_W-1:IR_USED];

  skip_cand_gen u_cand (
    .ir_i    (ir_i),
    .flags_i (flags),
    .cand_o  (cand)
  );

  skip_sel_pick u_pick (
    .sel_i  (cond_sel_i),
    .cand_i (cand),
    .hit_o  (hit)
  );

  skip_hold_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (hit),
    .q_o    (skip_o)
  );
endmodule

// File: rtl/uop_skip_eval_chk.sv
module uop_skip_eval_chk
  import skip_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] cond_sel_i,
  input logic [IR_W-1:0]  ir_i,
  input logic             flag_v_i,
  input logic             flag_l_i,
  input logic             flag_z_i,
  input logic             flag_n_i,
  input logic             skip_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) a_r1_reset_low: assert (skip_o == 1'b0);
  end

  a_r2_nop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i == 4'd0) |=> (skip_o == 1'b0));

  a_r3_ir_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i >= 4'd1 && cond_sel_i <= 4'd7)
      |=> (skip_o == $past(ir_i[{1'b0, cond_sel_i} + 5'd2])));

  a_r4_reserved_false: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i == 4'd8 || cond_sel_i == 4'd9) |=> (skip_o == 1'b0));

  a_r5_flag_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i == 4'd10) |=> (skip_o == $past(flag_v_i)));
  a_r5_flag_l: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i == 4'd11) |=> (skip_o == $past(flag_l_i)));
  a_r5_flag_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i == 4'd12) |=> (skip_o == $past(flag_z_i)));
  a_r5_flag_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i == 4'd13) |=> (skip_o == $past(flag_n_i)));

  a_r6_lo3_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i == 4'd14) |=> (skip_o == $past(ir_i[2:0] != 3'd0)));

  a_r7_lo4_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i == 4'd15) |=> (skip_o == $past(ir_i[3:0] != 4'd0)));
endmodule

bind uop_skip_eval uop_skip_eval_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cond_sel_i (cond_sel_i),
  .ir_i       (ir_i),
  .flag_v_i   (flag_v_i),
  .flag_l_i   (flag_l_i),
  .flag_z_i   (flag_z_i),
  .flag_n_i   (flag_n_i),
  .skip_o     (skip_o)
);

// File: tb/uop_skip_eval_tb.sv
`timescale 1ns/1ps
module uop_skip_eval_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  cond_sel_i = '0;
  logic [15:0] ir_i = '0;
  logic        flag_v_i = 1'b0, flag_l_i = 1'b0, flag_z_i = 1'b0, flag_n_i = 1'b0;
  logic        skip_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  uop_skip_eval u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_sel_i(cond_sel_i), .ir_i(ir_i),
    .flag_v_i(flag_v_i), .flag_l_i(flag_l_i), .flag_z_i(flag_z_i),
    .flag_n_i(flag_n_i), .skip_o(skip_o)
  );

  function automatic bit ref_skip(input int sel, input logic [15:0] ir,
                                  input bit v, input bit l, input bit z, input bit n);
    if (sel >= 1 && sel <= 7) return ir[sel + 2];
    case (sel)
      10: return v;
      11: return l;
      12: return z;
      13: return n;
      14: return (ir % 8) != 0;
      15: return (ir % 16) != 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input int sel);
    if (sel == 0) return "R2";
    if (sel <= 7) return "R3";
    if (sel <= 9) return "R4";
    if (sel <= 13) return "R5";
    if (sel == 14) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: skip_o=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; result checked one rising edge later
  task automatic step(input int sel, input logic [15:0] ir,
                      input bit v, input bit l, input bit z, input bit n);
    bit exp;
    cond_sel_i = 4'(sel); ir_i = ir;
    flag_v_i = v; flag_l_i = l; flag_z_i = z; flag_n_i = n;
    exp = ref_skip(sel, ir, v, l, z, n);
    @(negedge clk_i);
    check(req_of(sel), skip_o, exp);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", skip_o, 1'b0);
    rst_ni = 1'b1;

    // sweep every code over walking-one IR and single flags
    for (int sel = 0; sel < 16; sel++) begin
      for (int b = 0; b < 16; b++) step(sel, 16'(1 << b), 1'b0, 1'b0, 1'b0, 1'b0);
      step(sel, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b1);
      step(sel, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int f = 0; f < 4; f++)
        step(sel, 16'h0000, f == 0, f == 1, f == 2, f == 3);
    end

    // R6 / R7 boundaries of the low-field tests
    step(14, 16'h0008, 0, 0, 0, 0);
    step(15, 16'h0008, 0, 0, 0, 0);
    step(14, 16'hFFF0, 0, 0, 0, 0);
    step(15, 16'hFFF0, 0, 0, 0, 0);
    step(14, 16'h0004, 0, 0, 0, 0);
    step(15, 16'h0001, 0, 0, 0, 0);
    // R4: reserved codes with every operand set
    step(8, 16'hFFFF, 1, 1, 1, 1);
    step(9, 16'hFFFF, 1, 1, 1, 1);

    // R8: a true result lasts one cycle, then the newer code's result
    step(3, 16'h0020, 0, 0, 0, 0);
    check("R8", skip_o, 1'b1);
    step(3, 16'h0000, 0, 0, 0, 0);
    check("R8", skip_o, 1'b0);
    step(10, 16'h0000, 1, 0, 0, 0);
    step(0, 16'hFFFF, 1, 1, 1, 1);
    check("R8", skip_o, 1'b0);

    // R9: operand change between edges does not reach skip_o
    step(12, 16'h0000, 0, 0, 1, 0);
    flag_z_i = 1'b0;
    cond_sel_i = 4'd0;
    #1;
    check("R9", skip_o, 1'b1);
    @(negedge clk_i);
    check("R9", skip_o, 1'b0);

    // R1: asynchronous clear between edges
    step(15, 16'h000F, 0, 0, 0, 0);
    #0.5 rst_ni = 1'b0;
    #0.5;
    check("R1", skip_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r = $urandom();
      step(int'(r[3:0]), 16'($urandom()), r[4], r[5], r[6], r[7]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule